// File: doc/BRIEF.md
# Conversion Sequencer with Burst Scan

This block sequences an external successive-approximation converter. Control inputs select the channels, the converter clock divider, the resolution, the start source and the edge polarity. The block divides the system clock into a converter step strobe and drives the channel number and a trial code. It reads back one comparator bit per step. At the end of each conversion it raises a one-cycle result strobe that carries the channel and the 10-bit result.

Conversions start in one of three ways. A software command starts one immediately. A synchronised edge on one of six trigger inputs also starts one. In burst mode the block scans the selected channels back to back in ascending order. A run can trade resolution for speed, from 10 bits in 11 steps down to 3 bits in 4 steps. When the power-enable input is low, the block stays idle and abandons any conversion in progress.

Top module: `conv_sequencer`

## Requirements
- R1: A conversion of N bits lasts (N+1)·(cfg_div+1) system clocks, counted from the clock edge that accepts the start to the edge that raises res_valid. conv_step pulses once every cfg_div+1 clocks while a conversion runs.
- R2: cfg_mask bit i selects channel i. A single conversion uses the lowest selected channel. With an all-zero mask, no conversion starts.
- R3: The resolution code r (cfg_res, 0..7) gives N = 10 − r result bits and N+1 steps. Code 0 gives 10 bits in 11 steps, and code 7 gives 3 bits in 4 steps.
- R4: The N result bits sit in res_value[9:10−N] and the unused low bits read zero. The result equals the channel input truncated to N bits, with comparator = (input ≥ conv_trial).
- R5: In single mode (cfg_scan=0), start code 3'b000 starts nothing and 3'b001 starts a conversion on the next clock edge.
- R6: Start codes 3'b010..3'b111 select trig_in[code−2]. That input passes through two synchroniser flops and an edge detector, so a change driven in cycle k starts a conversion at the edge k+3. Edges on trig_in bits that are not selected are ignored.
- R7: cfg_falling=0 starts on a rising trigger edge, and cfg_falling=1 starts on a falling trigger edge. The opposite edge starts nothing.
- R8: With cfg_scan=1, the selected channels convert back to back in ascending order and wrap after the highest one. Clearing cfg_scan lets the conversion in progress finish and starts no further conversion. During burst the start code and the trigger inputs have no effect.
- R9: With cfg_power=0 no conversion starts. Dropping cfg_power during a conversion abandons it with no result.
- R10: A conversion started by code 3'b001 raises start_clr together with its res_valid, so that the register holding the code can clear it. The command never starts a second conversion in the cycle after start_clr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mask | input | 8 | Channel select mask |
| cfg_div | input | 8 | Converter clock divider (divide by value+1) |
| cfg_scan | input | 1 | Burst scan enable |
| cfg_res | input | 3 | Resolution code, N = 10 − code |
| cfg_power | input | 1 | Converter power enable, 1 = active |
| cfg_start | input | 3 | Start source code for single mode |
| cfg_falling | input | 1 | Trigger edge polarity, 1 = falling |
| trig_in | input | 6 | Asynchronous external trigger inputs |
| cmp_in | input | 1 | Comparator decision from the converter |
| conv_step | output | 1 | Converter step strobe |
| conv_chan | output | 3 | Channel being converted |
| conv_trial | output | 10 | Trial code presented to the comparator |
| res_valid | output | 1 | One-cycle result strobe |
| res_chan | output | 3 | Channel of the result |
| res_value | output | 10 | Left-aligned conversion result |
| start_clr | output | 1 | Clear request for the start-now code |

## Verification
The assertions check several rules on every cycle. After a tick with a non-zero divider, the next cycle has no step. A result always follows a busy cycle and has zero low bits below the resolution. A start clear never appears without a result, and the block goes idle one cycle after power drops. The pick logic always names a selected channel. Only the bench's scenarios can show the exact latency of each start source, the ascending and wrapping burst order and the truncated result values. They also show that foreign trigger edges, opposite edges, an empty mask and start codes during burst leave the outputs untouched.

// File: rtl/seq_pkg.sv
`timescale 1ns/1ps
package seq_pkg;
    localparam int SEQ_START_W = 3;
    localparam int SEQ_NTRIG   = 6;
    localparam logic [SEQ_START_W-1:0] START_NONE  = 3'd0;
    localparam logic [SEQ_START_W-1:0] START_NOW   = 3'd1;
    localparam logic [SEQ_START_W-1:0] START_TRIG0 = 3'd2;
endpackage

// File: rtl/seq_step_div.sv
`timescale 1ns/1ps
module seq_step_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    assign tick = run && (cnt_q >= div);

    always_comb begin
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R1: with a non-zero divider, steps never come on adjacent cycles
    p_step_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/seq_trig_edge.sv
`timescale 1ns/1ps
module seq_trig_edge #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] trig_in,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    for (genvar i = 0; i < N; i++) begin : g_sync
        logic [2:0] sh_d, sh_q;
        always_comb sh_d = {sh_q[1:0], trig_in[i]};
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= sh_d;
        end
        assign rise[i] =  sh_q[1] && !sh_q[2];
        assign fall[i] = !sh_q[1] &&  sh_q[2];
    end
endmodule

// File: rtl/seq_chan_pick.sv
`timescale 1ns/1ps
module seq_chan_pick #(
    parameter int NCH  = 8,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic [NCH-1:0]  mask,
    input  logic [CH_W-1:0] last,
    output logic [CH_W-1:0] next_ch
);
    logic [CH_W-1:0] low, above;
    logic            hit;

    always_comb begin
        low   = '0;
        above = '0;
        hit   = 1'b0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask[i]) begin
                low = CH_W'(i);
                if (i > int'(last)) begin
                    above = CH_W'(i);
                    hit   = 1'b1;
                end
            end
        end
        next_ch = hit ? above : low;
    end
endmodule

// File: rtl/conv_sequencer.sv
`timescale 1ns/1ps
module conv_sequencer
    import seq_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int DIV_W  = 8,
    parameter int RES_W  = 10,
    parameter int RSEL_W = 3,
    parameter int NTRIG  = SEQ_NTRIG
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCH-1:0]         cfg_mask,
    input  logic [DIV_W-1:0]       cfg_div,
    input  logic                   cfg_scan,
    input  logic [RSEL_W-1:0]      cfg_res,
    input  logic                   cfg_power,
    input  logic [SEQ_START_W-1:0] cfg_start,
    input  logic                   cfg_falling,
    input  logic [NTRIG-1:0]       trig_in,
    input  logic                   cmp_in,
    output logic                   conv_step,
    output logic [$clog2(NCH)-1:0] conv_chan,
    output logic [RES_W-1:0]       conv_trial,
    output logic                   res_valid,
    output logic [$clog2(NCH)-1:0] res_chan,
    output logic [RES_W-1:0]       res_value,
    output logic                   start_clr
);
    localparam int CH_W = $clog2(NCH);
    localparam int PH_W = $clog2(RES_W + 1);
    localparam logic [PH_W-1:0] RES_W_P = PH_W'(RES_W);
    localparam logic [CH_W-1:0] TOP_CH  = CH_W'(NCH - 1);

    typedef struct packed {
        logic             busy;
        logic             by_cmd;
        logic [PH_W-1:0]  phase;
        logic [PH_W-1:0]  bits;
        logic [CH_W-1:0]  chan;
        logic [RES_W-1:0] acc;
        logic             valid;
        logic [CH_W-1:0]  rchan;
        logic [RES_W-1:0] rval;
        logic [PH_W-1:0]  rbits;
        logic             clr;
    } st_t;

    st_t st_d, st_q;

    logic                   step;
    logic [NTRIG-1:0]       rise, fall;
    logic [CH_W-1:0]        pick_ch;
    logic [CH_W-1:0]        pick_last;
    logic [SEQ_START_W-1:0] tidx;
    logic                   trig_hit, go_now, mask_any, start_ok;
    logic [PH_W-1:0]        bits_cfg;
    logic [PH_W-1:0]        bitpos;
    logic [RES_W-1:0]       acc_new;

    seq_step_div #(.DIV_W(DIV_W)) i_div (
        .clk(clk), .rst_n(rst_n), .run(st_q.busy), .div(cfg_div), .tick(step)
    );

    seq_trig_edge #(.N(NTRIG)) i_trig (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .rise(rise), .fall(fall)
    );

    assign pick_last = st_q.busy ? st_q.chan : TOP_CH;

    seq_chan_pick #(.NCH(NCH), .CH_W(CH_W)) i_pick (
        .mask(cfg_mask), .last(pick_last), .next_ch(pick_ch)
    );

    assign tidx     = cfg_start - START_TRIG0;
    assign trig_hit = (cfg_start >= START_TRIG0) &&
                      (cfg_falling ? fall[tidx] : rise[tidx]);
    assign go_now   = (cfg_start == START_NOW) && !st_q.clr;
    assign mask_any = |cfg_mask;
    assign start_ok = cfg_power && mask_any && (cfg_scan || go_now || trig_hit);
    assign bits_cfg = RES_W_P - PH_W'(cfg_res);
    assign bitpos   = RES_W_P - st_q.phase;

    always_comb begin
        acc_new = st_q.acc;
        if (st_q.phase != '0) acc_new[bitpos] = cmp_in;
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.clr   = 1'b0;
        if (!st_q.busy) begin
            if (start_ok) begin
                st_d.busy   = 1'b1;
                st_d.by_cmd = !cfg_scan && go_now;
                st_d.phase  = '0;
                st_d.bits   = bits_cfg;
                st_d.chan   = pick_ch;
                st_d.acc    = '0;
            end
        end else if (!cfg_power) begin
            st_d.busy = 1'b0;
        end else if (step) begin
            if (st_q.phase == '0) begin
                st_d.phase = PH_W'(1);
            end else begin
                st_d.acc = acc_new;
                if (st_q.phase == st_q.bits) begin
                    st_d.valid = 1'b1;
                    st_d.rchan = st_q.chan;
                    st_d.rval  = acc_new;
                    st_d.rbits = st_q.bits;
                    st_d.clr   = st_q.by_cmd;
                    if (cfg_scan && mask_any) begin
                        st_d.phase  = '0;
                        st_d.acc    = '0;
                        st_d.chan   = pick_ch;
                        st_d.bits   = bits_cfg;
                        st_d.by_cmd = 1'b0;
                    end else begin
                        st_d.busy = 1'b0;
                    end
                end else begin
                    st_d.phase = st_q.phase + PH_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign conv_step  = step;
    assign conv_chan  = st_q.chan;
    assign conv_trial = st_q.acc |
        ((st_q.busy && st_q.phase != '0) ? (RES_W'(1) << bitpos) : '0);
    assign res_valid  = st_q.valid;
    assign res_chan   = st_q.rchan;
    assign res_value  = st_q.rval;
    assign start_clr  = st_q.clr;

    logic [RES_W-1:0] low_mask;
    assign low_mask = (RES_W'(1) << (RES_W_P - st_q.rbits)) - RES_W'(1);

    p_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((res_value & low_mask) == '0));
    p_result_after_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(st_q.busy));
    p_power_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_power |=> !st_q.busy);
    p_clr_with_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_clr |-> res_valid);
    p_pick_selected_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mask_any |-> cfg_mask[pick_ch]);
endmodule

// File: tb/test_conv_sequencer.sv
`timescale 1ns/1ps
module test_conv_sequencer;
    localparam int NCH = 8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] cfg_mask;
    logic [7:0] cfg_div;
    logic       cfg_scan;
    logic [2:0] cfg_res;
    logic       cfg_power;
    logic [2:0] cfg_start;
    logic       cfg_falling;
    logic [5:0] trig_in;
    logic       cmp_in;
    logic       conv_step;
    logic [2:0] conv_chan;
    logic [9:0] conv_trial;
    logic       res_valid;
    logic [2:0] res_chan;
    logic [9:0] res_value;
    logic       start_clr;

    always #2.5 clk = ~clk;

    conv_sequencer i_conv_sequencer (
        .clk(clk), .rst_n(rst_n), .cfg_mask(cfg_mask), .cfg_div(cfg_div),
        .cfg_scan(cfg_scan), .cfg_res(cfg_res), .cfg_power(cfg_power),
        .cfg_start(cfg_start), .cfg_falling(cfg_falling), .trig_in(trig_in),
        .cmp_in(cmp_in), .conv_step(conv_step), .conv_chan(conv_chan),
        .conv_trial(conv_trial), .res_valid(res_valid), .res_chan(res_chan),
        .res_value(res_value), .start_clr(start_clr)
    );

    int an [NCH] = '{1023, 0, 517, 300, 777, 64, 901, 333};
    always_comb cmp_in = an[conv_chan] >= int'(conv_trial);

    typedef struct {
        int    cyc;
        int    ch;
        int    val;
        bit    clr;
        string req;
    } exp_t;
    exp_t q[$];

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int n_res = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int sar(int ch, int nb);
        return (an[ch] >> (10 - nb)) << (10 - nb);
    endfunction

    function automatic int tconv(int nb, int dv);
        return (nb + 1) * (dv + 1);
    endfunction

    task automatic expect_at(int c, int ch, int nb, bit clr, string req);
        exp_t e;
        e.cyc = c; e.ch = ch; e.val = sar(ch, nb); e.clr = clr; e.req = req;
        q.push_back(e);
    endtask

    // cycle-by-cycle comparison against the expectation queue
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (res_valid) n_res++;
            if (q.size() > 0 && q[0].cyc < cyc) begin
                chk(0, q[0].req, 0, 1);
                void'(q.pop_front());
            end
            if (q.size() > 0 && q[0].cyc == cyc) begin
                chk(res_valid == 1'b1, q[0].req, int'(res_valid), 1);
                chk(int'(res_chan) == q[0].ch, q[0].req, int'(res_chan), q[0].ch);
                chk(int'(res_value) == q[0].val, q[0].req, int'(res_value), q[0].val);
                chk(start_clr == q[0].clr, "R10", int'(start_clr), int'(q[0].clr));
                void'(q.pop_front());
            end else if (res_valid || start_clr) begin
                chk(0, "R8 unexpected result", int'(res_valid), 0);
            end
            if (start_clr) cfg_start = 3'd0;
        end
    end

    task automatic waitn(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", cyc, 0);
        done = 1;
        report();
        $finish;
    end

    initial begin
        int base;
        int k;
        int stop;
        rst_n = 1'b0; cfg_mask = '0; cfg_div = '0; cfg_scan = 1'b0; cfg_res = '0;
        cfg_power = 1'b0; cfg_start = '0; cfg_falling = 1'b0; trig_in = '0;
        waitn(5);
        rst_n = 1'b1;
        @(negedge clk);
        chk(res_valid == 0, "reset", int'(res_valid), 0);
        chk(start_clr == 0, "reset", int'(start_clr), 0);
        chk(conv_step == 0, "reset", int'(conv_step), 0);

        // R5 R1 R2 R10: start-now, 10 bits, divide by 3, lowest of two channels
        cfg_power = 1; cfg_mask = 8'b0010_0100; cfg_div = 2; cfg_res = 0;
        base = n_res;
        @(negedge clk);
        cfg_start = 3'd1;
        expect_at(cyc + 1 + tconv(10, 2), 2, 10, 1, "R5");
        waitn(tconv(10, 2) + 15);
        chk(n_res - base == 1, "R10", n_res - base, 1);

        // R3: 3 bits, no division
        cfg_mask = 8'b1000_0000; cfg_div = 0; cfg_res = 7;
        @(negedge clk);
        cfg_start = 3'd1;
        expect_at(cyc + 1 + tconv(3, 0), 7, 3, 1, "R3");
        waitn(20);

        // R4: 7 bits, divide by 6
        cfg_mask = 8'b0000_1010; cfg_div = 5; cfg_res = 3;
        @(negedge clk);
        cfg_start = 3'd1;
        expect_at(cyc + 1 + tconv(7, 5), 1, 7, 1, "R4");
        waitn(tconv(7, 5) + 10);

        // R2: empty mask starts nothing
        cfg_mask = 8'b0; base = n_res;
        @(negedge clk);
        cfg_start = 3'd1;
        waitn(40);
        chk(n_res - base == 0, "R2", n_res - base, 0);
        cfg_start = 3'd0;

        // R9: power off blocks start, power on lets the pending command run
        cfg_power = 0; cfg_mask = 8'b0000_0001; cfg_div = 1; cfg_res = 7; base = n_res;
        @(negedge clk);
        cfg_start = 3'd1;
        waitn(30);
        chk(n_res - base == 0, "R9", n_res - base, 0);
        cfg_power = 1;
        expect_at(cyc + 1 + tconv(3, 1), 0, 3, 1, "R9");
        waitn(20);

        // R6 R7: rising edge on trig_in[1] with start code 3
        cfg_mask = 8'b0000_0100; cfg_div = 0; cfg_res = 0; cfg_falling = 0;
        cfg_start = 3'd3;
        waitn(3);
        trig_in[1] = 1'b1;
        expect_at(cyc + 3 + tconv(10, 0), 2, 10, 0, "R6");
        waitn(25);
        base = n_res;
        trig_in[1] = 1'b0;
        waitn(25);
        chk(n_res - base == 0, "R7", n_res - base, 0);
        trig_in[0] = 1'b1;
        waitn(5);
        trig_in[0] = 1'b0;
        waitn(25);
        chk(n_res - base == 0, "R6", n_res - base, 0);

        // R7: falling edge on trig_in[5] with start code 7
        cfg_start = 3'd7; cfg_falling = 1; base = n_res;
        waitn(3);
        trig_in[5] = 1'b1;
        waitn(25);
        chk(n_res - base == 0, "R7", n_res - base, 0);
        trig_in[5] = 1'b0;
        expect_at(cyc + 3 + tconv(10, 0), 2, 10, 0, "R7");
        waitn(25);
        cfg_start = 3'd0; cfg_falling = 0;

        // R8: burst over channels 0, 2, 7 with wrap, 5 bits, divide by 2
        cfg_mask = 8'b1000_0101; cfg_div = 1; cfg_res = 5;
        waitn(3);
        base = n_res;
        cfg_scan = 1;
        k = cyc + 1;
        for (int j = 0; j < 6; j++) begin
            int chs [3] = '{0, 2, 7};
            expect_at(k + (j + 1) * tconv(5, 1), chs[j % 3], 5, 0, "R8");
        end
        stop = k + 5 * tconv(5, 1);
        waitn(2 * tconv(5, 1));
        cfg_start = 3'd1;
        waitn(tconv(5, 1));
        cfg_start = 3'd2;
        trig_in[0] = 1'b1;
        waitn(5);
        trig_in[0] = 1'b0;
        cfg_start = 3'd0;
        while (cyc != stop) @(negedge clk);
        cfg_scan = 0;
        waitn(3 * tconv(5, 1));
        chk(n_res - base == 6, "R8", n_res - base, 6);
        chk(q.size() == 0, "R8", q.size(), 0);

        // R9: dropping power mid-burst abandons the conversion
        cfg_mask = 8'b0100_0000; cfg_div = 3; cfg_res = 0; base = n_res;
        @(negedge clk);
        cfg_scan = 1;
        waitn(20);
        cfg_power = 0;
        waitn(80);
        chk(n_res - base == 0, "R9", n_res - base, 0);
        cfg_scan = 0; cfg_power = 1;
        waitn(5);

        done = 1;
        report();
        $finish;
    end
endmodule